// File: doc/BRIEF.md
# Mailbox Transaction Sequencer

This block is the host side of a shared-memory mailbox. It drives a simple register bus to carry out two transactions. A send places a message in the shared window and waits for the far side to acknowledge it. A receive waits for the far side to post a message, then copies that message into a local buffer. The caller gives a command, which selects send or receive, and a word count. The message words come from, or go to, a small local buffer port indexed by word number. When the transaction ends, the block returns a one-cycle done pulse with an error flag.

Traffic is detected with two 16-bit counters that the far side keeps in one register. Requests from the far side are in bits 15:0 and acknowledges are in bits 31:16. The block holds its own copy of each counter. A counter signals new traffic only when it is nonzero and differs from the held copy; zero means that the far side has been reset.

The block keeps a matching pair of host counters in a second register. It bumps these with a read-modify-write that leaves the other half untouched. The shared window is guarded by a lock bit in a control register. The block acquires the lock by writing the bit and reading it back. The poll interval and the overall timeout are given in microseconds and turned into cycle counts through a clock-rate parameter.

Top module: `mbx_seq`

## Requirements
- R1: After reset, before accepting any command, the block reads the far-side counter register and keeps both halves as its held copies. It then writes 0 to the control register and 0xFFFF0000 to the mask register, and only then raises `cmd_ready`.
- R2: To acquire the lock, the block writes the control register with only the lock bit (bit 3) set, then reads the control register back. A readback with bit 3 set grants the lock. A refused attempt is followed by at least POLL_US*CLK_MHZ idle cycles before the next attempt.
- R3: A send takes the lock before any shared-window write. It then writes buffer word i to address SHM_BASE+i for i = 0 .. n-1.
- R4: After copying, a send keeps far-side bits 31:16 as its new held acknowledge. It adds 1, modulo 2^16, to host counter bits 15:0 while keeping bits 31:16. It then writes the control register with bit 0 (request) set and bit 3 clear.
- R5: A send ends without error once far-side bits 31:16 are nonzero and differ from the held acknowledge. If no such acknowledge arrives, it ends with `done_err`.
- R6: A receive first waits until far-side bits 15:0 are nonzero and differ from the held request count. It then takes the lock and stores word i, read from SHM_BASE+i, into buffer entry i.
- R7: After copying, a receive writes 0 to SHM_BASE and keeps far-side bits 15:0 as its new held request. It adds 1, modulo 2^16, to host counter bits 31:16 while keeping bits 15:0. It then writes 0 to the control register.
- R8: Any wait that has run for TIMEOUT_US*CLK_MHZ cycles ends the command at its next failed check, with `done` and `done_err`. At that point the lock is not held.
- R9: A word count above MAX_WORDS is treated as MAX_WORDS. A count of zero moves no message words.
- R10: `done` is a single-cycle pulse. A bus request keeps its address and data stable until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when `cmd_ready` is high |
| cmd_send | input | 1 | 1 = send, 0 = receive |
| cmd_words | input | WW | Message length in 32-bit words |
| cmd_ready | output | 1 | Idle and able to take a command |
| done | output | 1 | Command finished (one cycle) |
| done_err | output | 1 | With `done`: the command timed out |
| buf_addr | output | BA_W | Local buffer word index |
| buf_we | output | 1 | Local buffer write strobe (receive) |
| buf_wdata | output | 32 | Local buffer write data |
| buf_rdata | input | 32 | Local buffer read data for `buf_addr`, same cycle |
| bus_req | output | 1 | Register bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register word address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transfer complete |

## Verification
The embedded assertions check several rules on every cycle. Each shared-window write must happen while the lock is held, and a request must stay stable until it is acknowledged. The release write must carry the right request bit and a clear lock bit. The counter write must change only its own half, and `done` must be a single-cycle pulse. Other behaviours can be shown only by the bench's scenarios against a register model. These are the copy contents for every length from 0 to past the limit, counter wrap, and the saved counts taken at initialisation. They also cover refused lock attempts with their spacing, and the timeout windows of each wait.

// File: rtl/mbxs_pkg.sv
package mbxs_pkg;
    typedef enum logic [3:0] {
        ST_INIT_RD,
        ST_INIT_CTRL,
        ST_INIT_MASK,
        ST_IDLE,
        ST_POLL_RD,
        ST_POLL_WAIT,
        ST_LOCK_WR,
        ST_LOCK_RD,
        ST_LOCK_WAIT,
        ST_COPY,
        ST_CLR,
        ST_SNAP,
        ST_CNT_RD,
        ST_CNT_WR,
        ST_REL
    } state_t;

    localparam logic [31:0] MASK_INIT = 32'hFFFF_0000;
endpackage

// File: rtl/mbxs_timer.sv
module mbxs_timer #(
    parameter int unsigned POLL_CYC = 4,
    parameter int unsigned TMO_CYC  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic arm,
    output logic expired,
    output logic gap_done
);
    localparam int unsigned EW = $clog2(TMO_CYC + 1);
    localparam int unsigned GW = (POLL_CYC > 1) ? $clog2(POLL_CYC + 1) : 1;
    localparam logic [EW-1:0] TMO_V    = EW'(TMO_CYC);
    localparam logic [GW-1:0] GAP_LOAD = GW'(POLL_CYC - 1);

    typedef struct packed {
        logic [EW-1:0] elapsed;
        logic [GW-1:0] gap;
    } tmr_t;

    tmr_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (restart)
            t_d.elapsed = '0;
        else if (t_q.elapsed != TMO_V)
            t_d.elapsed = t_q.elapsed + 1'b1;
        if (arm)
            t_d.gap = GAP_LOAD;
        else if (t_q.gap != '0)
            t_d.gap = t_q.gap - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign expired  = (t_q.elapsed == TMO_V);
    assign gap_done = (t_q.gap == '0);

    // R8: once the window has run out it stays out until restarted
    assert_expiry_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !restart) |=> expired);

    // R2: an armed gap counts down one step per cycle
    assert_gap_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !gap_done) |=> (t_q.gap == $past(t_q.gap) - 1'b1));
endmodule

// File: rtl/mbxs_cnt_bump.sv
module mbxs_cnt_bump (
    input  logic [31:0] cur,
    input  logic        hi_half,
    output logic [31:0] nxt
);
    always_comb begin
        nxt = cur;
        if (hi_half) nxt[31:16] = cur[31:16] + 16'd1;
        else         nxt[15:0]  = cur[15:0] + 16'd1;
    end
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
    import mbxs_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned MAX_WORDS  = 16,
    parameter int unsigned CLK_MHZ    = 250,
    parameter int unsigned POLL_US    = 100,
    parameter int unsigned TIMEOUT_US = 4_000_000,
    parameter int unsigned LOCK_BIT   = 3,
    parameter int unsigned REQ_BIT    = 0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h00,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 'h01,
    parameter logic [ADDR_W-1:0] FWCNT_ADDR = 'h02,
    parameter logic [ADDR_W-1:0] HOSTCNT_ADDR = 'h03,
    parameter logic [ADDR_W-1:0] SHM_BASE = 'h10,
    localparam int unsigned WW   = $clog2(MAX_WORDS + 1),
    localparam int unsigned BA_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_send,
    input  logic [WW-1:0]     cmd_words,
    output logic              cmd_ready,
    output logic              done,
    output logic              done_err,
    output logic [BA_W-1:0]   buf_addr,
    output logic              buf_we,
    output logic [31:0]       buf_wdata,
    input  logic [31:0]       buf_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack
);
    localparam int unsigned POLL_CYC = CLK_MHZ * POLL_US;
    localparam int unsigned TMO_CYC  = CLK_MHZ * TIMEOUT_US;
    localparam logic [WW-1:0] MAXW   = WW'(MAX_WORDS);
    localparam logic [31:0] LOCK_MASK = 32'(1) << LOCK_BIT;
    localparam logic [31:0] REQ_MASK  = 32'(1) << REQ_BIT;

    typedef struct packed {
        state_t      st;
        logic        send;
        logic [WW-1:0] words;
        logic [WW-1:0] idx;
        logic [15:0] seen_req;
        logic [15:0] seen_ack;
        logic [31:0] cnt_word;
        logic        held;
        logic        done;
        logic        err;
    } seq_t;

    seq_t s_q, s_d;

    logic        tmr_restart, tmr_arm, tmr_expired, tmr_gap_done;
    logic [31:0] cnt_next;
    logic [15:0] poll_val, poll_seen;
    state_t      after_copy;

    mbxs_timer #(.POLL_CYC(POLL_CYC), .TMO_CYC(TMO_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (tmr_restart),
        .arm      (tmr_arm),
        .expired  (tmr_expired),
        .gap_done (tmr_gap_done)
    );

    // receive bumps the acknowledge half, send bumps the request half
    mbxs_cnt_bump u_bump (
        .cur     (s_q.cnt_word),
        .hi_half (!s_q.send),
        .nxt     (cnt_next)
    );

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.err     = 1'b0;
        bus_req     = 1'b0;
        bus_we      = 1'b0;
        bus_addr    = CTRL_ADDR;
        bus_wdata   = '0;
        buf_we      = 1'b0;
        tmr_restart = 1'b0;
        tmr_arm     = 1'b0;
        poll_val    = s_q.send ? bus_rdata[31:16] : bus_rdata[15:0];
        poll_seen   = s_q.send ? s_q.seen_ack : s_q.seen_req;
        after_copy  = s_q.send ? ST_SNAP : ST_CLR;

        case (s_q.st)
            ST_INIT_RD: begin
                bus_req  = 1'b1;
                bus_addr = FWCNT_ADDR;
                if (bus_ack) begin
                    s_d.seen_req = bus_rdata[15:0];
                    s_d.seen_ack = bus_rdata[31:16];
                    s_d.st       = ST_INIT_CTRL;
                end
            end
            ST_INIT_CTRL: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
                if (bus_ack) s_d.st = ST_INIT_MASK;
            end
            ST_INIT_MASK: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = MASK_ADDR;
                bus_wdata = MASK_INIT;
                if (bus_ack) s_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (cmd_valid) begin
                    s_d.send    = cmd_send;
                    s_d.words   = (cmd_words > MAXW) ? MAXW : cmd_words;
                    s_d.idx     = '0;
                    tmr_restart = 1'b1;
                    s_d.st      = cmd_send ? ST_LOCK_WR : ST_POLL_RD;
                end
            end
            ST_POLL_RD: begin
                bus_req  = 1'b1;
                bus_addr = FWCNT_ADDR;
                if (bus_ack) begin
                    if (poll_val != 16'd0 && poll_val != poll_seen) begin
                        if (s_q.send) begin
                            s_d.done = 1'b1;
                            s_d.st   = ST_IDLE;
                        end else begin
                            tmr_restart = 1'b1;
                            s_d.st      = ST_LOCK_WR;
                        end
                    end else if (tmr_expired) begin
                        s_d.done = 1'b1;
                        s_d.err  = 1'b1;
                        s_d.st   = ST_IDLE;
                    end else begin
                        tmr_arm = 1'b1;
                        s_d.st  = ST_POLL_WAIT;
                    end
                end
            end
            ST_POLL_WAIT: if (tmr_gap_done) s_d.st = ST_POLL_RD;
            ST_LOCK_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = LOCK_MASK;
                if (bus_ack) s_d.st = ST_LOCK_RD;
            end
            ST_LOCK_RD: begin
                bus_req = 1'b1;
                if (bus_ack) begin
                    if (bus_rdata[LOCK_BIT]) begin
                        s_d.held = 1'b1;
                        s_d.st   = (s_q.words == '0) ? after_copy : ST_COPY;
                    end else if (tmr_expired) begin
                        s_d.done = 1'b1;
                        s_d.err  = 1'b1;
                        s_d.st   = ST_IDLE;
                    end else begin
                        tmr_arm = 1'b1;
                        s_d.st  = ST_LOCK_WAIT;
                    end
                end
            end
            ST_LOCK_WAIT: if (tmr_gap_done) s_d.st = ST_LOCK_WR;
            ST_COPY: begin
                bus_req   = 1'b1;
                bus_we    = s_q.send;
                bus_addr  = SHM_BASE + ADDR_W'(s_q.idx);
                bus_wdata = buf_rdata;
                if (bus_ack) begin
                    buf_we  = !s_q.send;
                    s_d.idx = s_q.idx + 1'b1;
                    if (s_q.idx + 1'b1 == s_q.words) s_d.st = after_copy;
                end
            end
            ST_CLR: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = SHM_BASE;
                if (bus_ack) s_d.st = ST_SNAP;
            end
            ST_SNAP: begin
                bus_req  = 1'b1;
                bus_addr = FWCNT_ADDR;
                if (bus_ack) begin
                    if (s_q.send) s_d.seen_ack = bus_rdata[31:16];
                    else          s_d.seen_req = bus_rdata[15:0];
                    s_d.st = ST_CNT_RD;
                end
            end
            ST_CNT_RD: begin
                bus_req  = 1'b1;
                bus_addr = HOSTCNT_ADDR;
                if (bus_ack) begin
                    s_d.cnt_word = bus_rdata;
                    s_d.st       = ST_CNT_WR;
                end
            end
            ST_CNT_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = HOSTCNT_ADDR;
                bus_wdata = cnt_next;
                if (bus_ack) s_d.st = ST_REL;
            end
            ST_REL: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = s_q.send ? REQ_MASK : 32'd0;
                if (bus_ack) begin
                    s_d.held = 1'b0;
                    if (s_q.send) begin
                        tmr_restart = 1'b1;
                        s_d.st      = ST_POLL_RD;
                    end else begin
                        s_d.done = 1'b1;
                        s_d.st   = ST_IDLE;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_INIT_RD;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_ready = (s_q.st == ST_IDLE);
    assign done      = s_q.done;
    assign done_err  = s_q.err;
    assign buf_addr  = s_q.idx[BA_W-1:0];
    assign buf_wdata = bus_rdata;

    // R3: shared-window writes only under the lock
    assert_shm_write_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr >= SHM_BASE) |-> s_q.held);

    // R10: a pending request keeps its shape until acknowledged
    assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_wdata)));

    // R10: done lasts one cycle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4 / R7: the counter write touches only its own half, wrapping mod 2^16
    assert_cnt_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == HOSTCNT_ADDR && s_q.send) |->
        (bus_wdata[31:16] == s_q.cnt_word[31:16] &&
         bus_wdata[15:0] == s_q.cnt_word[15:0] + 16'd1));
    assert_cnt_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == HOSTCNT_ADDR && !s_q.send) |->
        (bus_wdata[15:0] == s_q.cnt_word[15:0] &&
         bus_wdata[31:16] == s_q.cnt_word[31:16] + 16'd1));

    // R4 / R7: release drops the lock bit, request bit only on a send
    assert_release_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_REL && bus_req) |->
        (!bus_wdata[LOCK_BIT] && bus_wdata[REQ_BIT] == s_q.send));

    // R8: a command never ends while the lock is held
    assert_end_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !s_q.held);
endmodule

// File: tb/mbx_seq_test.sv
module mbx_seq_test;
    localparam int MW   = 8;
    localparam int POLL = 4;
    localparam int TMO  = 120;
    localparam int WW   = $clog2(MW + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          cmd_valid = 1'b0, cmd_send = 1'b0;
    logic [WW-1:0] cmd_words = '0;
    logic          cmd_ready, done, done_err;
    logic [2:0]    buf_addr;
    logic          buf_we;
    logic [31:0]   buf_wdata, buf_rdata;
    logic          bus_req, bus_we;
    logic [7:0]    bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata = '0;
    logic          bus_ack = 1'b0;

    mbx_seq #(.ADDR_W(8), .MAX_WORDS(MW), .CLK_MHZ(1), .POLL_US(POLL),
              .TIMEOUT_US(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_send(cmd_send),
        .cmd_words(cmd_words), .cmd_ready(cmd_ready), .done(done),
        .done_err(done_err), .buf_addr(buf_addr), .buf_we(buf_we),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    // register model of the mailbox
    logic [31:0] r_ctrl, r_mask, r_fw, r_host;
    logic [31:0] shm [MW];
    logic [31:0] lbuf [MW];
    int deny_left = 0, ack_pend = 0, lock_tries = 0, unlocked_wr = 0, oob_wr = 0;
    int last_try = 0, min_gap = 1000000, cyc = 0;
    bit auto_ack = 1'b1;
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    assign buf_rdata = lbuf[buf_addr];
    always @(posedge clk) if (buf_we) lbuf[buf_addr] <= buf_wdata;

    always @(posedge clk) begin
        cyc++;
        if (ack_pend > 0) begin
            ack_pend--;
            if (ack_pend == 0) r_fw[31:16] = r_fw[31:16] + 16'd1;
        end
        if (bus_ack) bus_ack <= 1'b0;
        else if (bus_req) begin
            bus_ack <= 1'b1;
            if (bus_we) begin
                if (bus_addr == 8'h00) begin
                    if (bus_wdata[3]) begin
                        lock_tries++;
                        if (lock_tries > 1 && cyc - last_try < min_gap) min_gap = cyc - last_try;
                        last_try = cyc;
                        if (deny_left > 0) begin
                            deny_left--;
                            r_ctrl = bus_wdata & ~32'h8;
                        end else r_ctrl = bus_wdata;
                    end else begin
                        r_ctrl = bus_wdata;
                        if (bus_wdata[0] && auto_ack) ack_pend = 6;
                    end
                end else if (bus_addr == 8'h01) r_mask = bus_wdata;
                else if (bus_addr == 8'h03) r_host = bus_wdata;
                else if (bus_addr >= 8'h10 && bus_addr < 8'h10 + MW) begin
                    if (!r_ctrl[3]) unlocked_wr++;
                    shm[bus_addr - 8'h10] = bus_wdata;
                end else if (bus_addr != 8'h02) oob_wr++;
            end else begin
                case (bus_addr)
                    8'h00: bus_rdata <= r_ctrl;
                    8'h01: bus_rdata <= r_mask;
                    8'h02: bus_rdata <= r_fw;
                    8'h03: bus_rdata <= r_host;
                    default:
                        if (bus_addr >= 8'h10 && bus_addr < 8'h10 + MW)
                            bus_rdata <= shm[bus_addr - 8'h10];
                        else bus_rdata <= 32'hDEAD_BEEF;
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    bit   last_err;
    int   last_cyc;

    task automatic run_cmd(input bit snd, input int words);
        int t;
        @(negedge clk);
        t = 0;
        while (!cmd_ready && t < 2000) begin @(negedge clk); t++; end
        cmd_valid = 1'b1; cmd_send = snd; cmd_words = WW'(words);
        @(negedge clk);
        cmd_valid = 1'b0;
        t = 1;
        while (!done && t < 3000) begin @(negedge clk); t++; end
        check(done == 1'b1, "R10 command completes", 32'(done), 32'd1);
        last_err = done_err;
        last_cyc = t;
        @(negedge clk);
        check(done == 1'b0, "R10 done single pulse", 32'(done), 32'd0);
    endtask

    function automatic logic [31:0] pat(input int n, input int i);
        return 32'hA500_0000 ^ (32'(n) << 12) ^ (32'(i) * 32'h0101_0011);
    endfunction

    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            n_fail++;
            $display("FAIL R10 watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] keep;
        r_ctrl = 32'h0000_00AA; r_mask = 32'h0; r_fw = {16'h0005, 16'h0009};
        r_host = 32'h0;
        for (int i = 0; i < MW; i++) begin shm[i] = 32'h0; lbuf[i] = 32'h0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check(cmd_ready == 1'b0, "R1 not ready during init", 32'(cmd_ready), 32'd0);
        repeat (20) @(negedge clk);
        check(cmd_ready == 1'b1, "R1 ready after init", 32'(cmd_ready), 32'd1);
        check(r_ctrl == 32'h0, "R1 control cleared", r_ctrl, 32'h0);
        check(r_mask == 32'hFFFF_0000, "R1 mask written", r_mask, 32'hFFFF_0000);

        // R1: held request count came from init, so an unchanged count times out
        run_cmd(1'b0, 2);
        check(last_err == 1'b1, "R1 saved request from init", 32'(last_err), 32'd1);
        check(last_cyc >= TMO && last_cyc <= TMO + POLL + 12, "R8 receive timeout window",
              32'(last_cyc), 32'(TMO));
        check(lock_tries == 0 && r_ctrl[3] == 1'b0, "R8 no lock after receive timeout",
              32'(lock_tries), 32'd0);

        // send sweep, every length 0..MW
        for (int n = 0; n <= MW; n++) begin
            for (int i = 0; i < MW; i++) begin lbuf[i] = pat(n, i); shm[i] = 32'hDEAD_0000; end
            r_host = {16'h1234, 16'(16'h0100 + n)};
            run_cmd(1'b1, n);
            check(last_err == 1'b0, "R5 send acknowledged", 32'(last_err), 32'd0);
            for (int i = 0; i < MW; i++) begin
                if (i < n) check(shm[i] == pat(n, i), "R3 send word copied", shm[i], pat(n, i));
                else check(shm[i] == 32'hDEAD_0000, "R9 send no extra word", shm[i], 32'hDEAD_0000);
            end
            check(r_host == {16'h1234, 16'(16'h0101 + n)}, "R4 host request bumped",
                  r_host, {16'h1234, 16'(16'h0101 + n)});
            check(r_ctrl == 32'h1, "R4 release with request", r_ctrl, 32'h1);
        end
        check(unlocked_wr == 0, "R3 writes under lock", 32'(unlocked_wr), 32'd0);

        // receive sweep, every length 0..MW
        for (int n = 0; n <= MW; n++) begin
            for (int i = 0; i < MW; i++) begin shm[i] = pat(n + 20, i); lbuf[i] = 32'h0; end
            r_host = {16'(16'h0200 + n), 16'h4321};
            r_fw[15:0] = r_fw[15:0] + 16'd1;
            run_cmd(1'b0, n);
            check(last_err == 1'b0, "R6 receive completes", 32'(last_err), 32'd0);
            for (int i = 0; i < MW; i++) begin
                if (i < n) check(lbuf[i] == pat(n + 20, i), "R6 receive word", lbuf[i], pat(n + 20, i));
                else check(lbuf[i] == 32'h0, "R9 receive no extra word", lbuf[i], 32'h0);
            end
            check(shm[0] == 32'h0, "R7 first word cleared", shm[0], 32'h0);
            check(r_host == {16'(16'h0201 + n), 16'h4321}, "R7 host ack bumped",
                  r_host, {16'(16'h0201 + n), 16'h4321});
            check(r_ctrl == 32'h0, "R7 release without request", r_ctrl, 32'h0);
        end

        // R9: count above the limit is clamped
        for (int i = 0; i < MW; i++) begin lbuf[i] = pat(77, i); shm[i] = 32'h0; end
        run_cmd(1'b1, 12);
        check(shm[MW-1] == pat(77, MW - 1) && oob_wr == 0, "R9 clamp to MAX_WORDS",
              32'(oob_wr), 32'd0);

        // R4 / R7 wrap
        r_host = {16'hABCD, 16'hFFFF};
        run_cmd(1'b1, 1);
        check(r_host == {16'hABCD, 16'h0000}, "R4 request count wraps", r_host, {16'hABCD, 16'h0000});
        r_host = {16'hFFFF, 16'h5A5A};
        r_fw[15:0] = r_fw[15:0] + 16'd1;
        run_cmd(1'b0, 1);
        check(r_host == {16'h0000, 16'h5A5A}, "R7 ack count wraps", r_host, {16'h0000, 16'h5A5A});

        // R6 / R8: zero request count means reset, no message
        keep = r_fw[15:0];
        r_fw[15:0] = 16'h0;
        lock_tries = 0;
        run_cmd(1'b0, 1);
        check(last_err == 1'b1 && lock_tries == 0, "R6 zero count ignored", 32'(last_err), 32'd1);
        r_fw[15:0] = keep;

        // R2: three refusals then grant
        lock_tries = 0; min_gap = 1000000; deny_left = 3;
        run_cmd(1'b1, 2);
        check(last_err == 1'b0, "R2 grant after refusals", 32'(last_err), 32'd0);
        check(lock_tries == 4, "R2 attempt count", 32'(lock_tries), 32'd4);
        check(min_gap >= POLL, "R2 attempt spacing", 32'(min_gap), 32'(POLL));

        // R2 / R8: lock never granted
        deny_left = 100000;
        for (int i = 0; i < MW; i++) shm[i] = 32'h1111_0000;
        run_cmd(1'b1, 3);
        check(last_err == 1'b1, "R8 lock timeout error", 32'(last_err), 32'd1);
        check(last_cyc >= TMO && last_cyc <= TMO + POLL + 14, "R8 lock timeout window",
              32'(last_cyc), 32'(TMO));
        check(shm[0] == 32'h1111_0000 && r_ctrl[3] == 1'b0, "R8 nothing copied unlocked",
              shm[0], 32'h1111_0000);
        deny_left = 0;

        // R5: no acknowledge from the far side
        auto_ack = 1'b0;
        r_host = 32'h0000_0010;
        run_cmd(1'b1, 1);
        check(last_err == 1'b1, "R5 missing ack times out", 32'(last_err), 32'd1);
        check(r_host == 32'h0000_0011, "R4 request bumped before ack wait", r_host, 32'h0000_0011);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule